// File: doc/BRIEF.md
# Closest-Rate Divider Search Engine

This block chooses settings for a two-stage clock divider. The parent rate first passes through a fixed pre-divider, then through a fixed divide-by-ten stage. After that comes a power-of-two stage selected by N, and finally an integer stage that divides by M plus a fixed offset. Given a parent rate and a requested rate, the engine walks every (M, N) pair. It keeps the setting whose output rate comes closest to the request without going over it.

A host pulses `start_i` with both rates present on the inputs. The engine latches them and raises `busy_o`. It evaluates each candidate in turn on one shared bit-serial divider. When all candidates are done, it pulses `done_o` for one cycle. The chosen M, N and resulting rate stay on the outputs until the next accepted start. The pre-divider and M offset are elaboration-time parameters. M_OFFSET must be at least 1.

Top module: `rate_grid_search`

## Requirements
- R1: Each candidate rate is ((parent / PRE_DIV) / 10 >> N) / (M + M_OFFSET), with every division truncating toward zero.
- R2: Candidates are visited with M as the outer loop from 0 to M_COUNT-1 and N as the inner loop from 0 to N_COUNT-1, so (M=0,N=1) is visited before (M=1,N=0).
- R3: A candidate whose rate exceeds the target rate is never selected, so `best_rate_o` never exceeds the latched target.
- R4: A candidate replaces the current choice only when its absolute distance from the target is strictly smaller; on equal distance the earlier candidate in scan order is kept.
- R5: The choice starts each search at M=0, N=0, rate 0, so when no candidate is nonzero and at or below the target the outputs read 0, 0, 0.
- R6: `done_o` is high for exactly one cycle, on the cycle after 128×(RATE_W+2) rising edges counted from the edge that accepts the start (4352 with defaults). `busy_o` is high from the cycle after that edge through the `done_o` cycle and low on the cycle after it.
- R7: A `start_i` pulse while `busy_o` is high is ignored: the running search keeps its latched rates and timing, and no extra `done_o` pulse results.
- R8: After reset all outputs are zero. After a search, `best_m_o`, `best_n_o` and `best_rate_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| parent_rate_i | input | RATE_W | Parent clock rate, sampled with the accepted start |
| target_rate_i | input | RATE_W | Requested rate, sampled with the accepted start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the search ends |
| best_m_o | output | clog2(M_COUNT) | Selected M setting |
| best_n_o | output | clog2(N_COUNT) | Selected N setting |
| best_rate_o | output | RATE_W | Output rate of the selected setting |

## Verification
The bench records the cycle count on the negative edge at which it drives a start. With defaults, the matching `done_o` must be seen 4353 counter ticks later. That count is the 4352 edges of R6 plus the accepting edge itself. The selected M, N and rate are compared at that same negative edge. `busy_o` is checked one negative edge after the start and again one after `done_o`. Because every sample happens at a negative edge, there is half a cycle of margin to each register update. A `done_o` that arrives early, late, or without a queued expectation is reported as a failure.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

  // Fixed divide stage that follows the pre-divider.
  localparam int unsigned FIXED_DIV = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } scan_state_e;

endpackage

// File: rtl/rgs_serial_div.sv
// Restoring divider, one quotient bit per cycle.
module rgs_serial_div #(
  parameter int DIVIDEND_W = 32,
  parameter int DIVISOR_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic [DIVIDEND_W-1:0] dividend_i,
  input  logic [DIVISOR_W-1:0]  divisor_i,
  output logic                  busy_o,
  output logic                  valid_o,
  output logic [DIVIDEND_W-1:0] quot_o
);

  localparam int CNT_W = $clog2(DIVIDEND_W + 1);

  logic [DIVISOR_W-1:0]  rem_q;
  logic [DIVISOR_W-1:0]  dsr_q;
  logic [DIVIDEND_W-1:0] quo_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  busy_q;
  logic                  valid_q;

  // One restoring step: shift in the next dividend bit, subtract when it fits.
  function automatic logic [DIVISOR_W+DIVIDEND_W-1:0] div_step(
    input logic [DIVISOR_W-1:0]  rem,
    input logic [DIVIDEND_W-1:0] quo,
    input logic [DIVISOR_W-1:0]  dsr
  );
    logic [DIVISOR_W:0] sh;
    logic               qbit;
    sh   = {rem, quo[DIVIDEND_W-1]};
    qbit = 1'b0;
    if (sh >= {1'b0, dsr}) begin
      sh   = sh - {1'b0, dsr};
      qbit = 1'b1;
    end
    return {sh[DIVISOR_W-1:0], quo[DIVIDEND_W-2:0], qbit};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      dsr_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (go_i) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dsr_q  <= divisor_i;
        cnt_q  <= CNT_W'(DIVIDEND_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        {rem_q, quo_q} <= div_step(rem_q, quo_q, dsr_q);
        cnt_q          <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign quot_o  = quo_q;

  // R1: the partial remainder stays below the divisor throughout a division.
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < dsr_q));

  // R6: a launch always starts a division.
  a_r6_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> busy_q);

endmodule

// File: rtl/rgs_scan_ctrl.sv
// Walks the (M, N) grid: M outer, N inner, one division per candidate.
module rgs_scan_ctrl
  import rgs_pkg::*;
#(
  parameter int M_COUNT = 16,
  parameter int N_COUNT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       div_valid_i,
  output logic                       accept_o,
  output logic                       issue_o,
  output logic                       eval_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [$clog2(M_COUNT)-1:0] m_o,
  output logic [$clog2(N_COUNT)-1:0] n_o
);

  localparam int M_W = $clog2(M_COUNT);
  localparam int N_W = $clog2(N_COUNT);
  localparam logic [M_W-1:0] M_LAST = M_W'(M_COUNT - 1);
  localparam logic [N_W-1:0] N_LAST = N_W'(N_COUNT - 1);

  scan_state_e    state_q;
  logic [M_W-1:0] m_q;
  logic [N_W-1:0] n_q;
  logic           last_cand;

  assign last_cand = (m_q == M_LAST) && (n_q == N_LAST);
  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign issue_o   = (state_q == ST_ISSUE);
  assign eval_o    = (state_q == ST_WAIT) && div_valid_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FINISH);
  assign m_o       = m_q;
  assign n_o       = n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      m_q     <= '0;
      n_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          m_q     <= '0;
          n_q     <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (div_valid_i) begin
          if (last_cand) begin
            state_q <= ST_FINISH;
          end else begin
            if (n_q == N_LAST) begin
              n_q <= '0;
              m_q <= m_q + M_W'(1);
            end else begin
              n_q <= n_q + N_W'(1);
            end
            state_q <= ST_ISSUE;
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: done is a single-cycle pulse.
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: an evaluation that is not the last one moves to the next candidate.
  a_r2_scan_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_o && !last_cand) |=> (issue_o && ((m_q != $past(m_q)) || (n_q != $past(n_q)))));

endmodule

// File: rtl/rgs_best_track.sv
// Keeps the best candidate seen so far, never above the target.
module rgs_best_track #(
  parameter int RATE_W = 32,
  parameter int M_W    = 4,
  parameter int N_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              eval_i,
  input  logic [RATE_W-1:0] target_i,
  input  logic [RATE_W-1:0] cand_rate_i,
  input  logic [M_W-1:0]    cand_m_i,
  input  logic [N_W-1:0]    cand_n_i,
  output logic [RATE_W-1:0] best_rate_o,
  output logic [M_W-1:0]    best_m_o,
  output logic [N_W-1:0]    best_n_o
);

  function automatic logic [RATE_W-1:0] abs_gap(
    input logic [RATE_W-1:0] a,
    input logic [RATE_W-1:0] b
  );
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  logic [RATE_W-1:0] best_rate_q;
  logic [M_W-1:0]    best_m_q;
  logic [N_W-1:0]    best_n_q;
  logic              cand_fits;
  logic              cand_closer;
  logic              take_cand;

  assign cand_fits   = (cand_rate_i <= target_i);
  assign cand_closer = abs_gap(target_i, cand_rate_i) < abs_gap(target_i, best_rate_q);
  assign take_cand   = eval_i && cand_fits && cand_closer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_rate_q <= '0;
      best_m_q    <= '0;
      best_n_q    <= '0;
    end else if (clear_i) begin
      best_rate_q <= '0;
      best_m_q    <= '0;
      best_n_q    <= '0;
    end else if (take_cand) begin
      best_rate_q <= cand_rate_i;
      best_m_q    <= cand_m_i;
      best_n_q    <= cand_n_i;
    end
  end

  assign best_rate_o = best_rate_q;
  assign best_m_o    = best_m_q;
  assign best_n_o    = best_n_q;

  // R3: the kept rate never exceeds the latched target.
  a_r3_not_above: assert property (@(posedge clk) disable iff (!rst_n)
    best_rate_q <= target_i);

  // R4: a replacement always moves strictly closer, i.e. the rate rises.
  a_r4_strict_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cand && !clear_i) |=> (best_rate_q > $past(best_rate_q)));

endmodule

// File: rtl/rate_grid_search.sv
module rate_grid_search
  import rgs_pkg::*;
#(
  parameter int RATE_W   = 32,
  parameter int M_COUNT  = 16,
  parameter int N_COUNT  = 8,
  parameter int PRE_DIV  = 2,
  parameter int M_OFFSET = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [RATE_W-1:0]          parent_rate_i,
  input  logic [RATE_W-1:0]          target_rate_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [$clog2(M_COUNT)-1:0] best_m_o,
  output logic [$clog2(N_COUNT)-1:0] best_n_o,
  output logic [RATE_W-1:0]          best_rate_o
);

  localparam int M_W   = $clog2(M_COUNT);
  localparam int N_W   = $clog2(N_COUNT);
  localparam int DSR_W = $clog2(M_COUNT + M_OFFSET);

  // Pre-divider and fixed divide-by-ten, applied once per search.
  function automatic logic [RATE_W-1:0] scale_parent(input logic [RATE_W-1:0] p);
    logic [RATE_W-1:0] pre;
    pre = p / RATE_W'(PRE_DIV);
    return pre / RATE_W'(FIXED_DIV);
  endfunction

  logic [RATE_W-1:0] base_q;
  logic [RATE_W-1:0] target_q;
  logic              accept;
  logic              issue;
  logic              eval;
  logic [M_W-1:0]    cur_m;
  logic [N_W-1:0]    cur_n;
  logic              div_busy;
  logic              div_valid;
  logic [RATE_W-1:0] div_quot;
  logic [RATE_W-1:0] cand_dividend;
  logic [DSR_W-1:0]  cand_divisor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      target_q <= '0;
    end else if (accept) begin
      base_q   <= scale_parent(parent_rate_i);
      target_q <= target_rate_i;
    end
  end

  assign cand_dividend = base_q >> cur_n;
  assign cand_divisor  = DSR_W'(cur_m) + DSR_W'(M_OFFSET);

  rgs_scan_ctrl #(
    .M_COUNT(M_COUNT),
    .N_COUNT(N_COUNT)
  ) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .div_valid_i (div_valid),
    .accept_o    (accept),
    .issue_o     (issue),
    .eval_o      (eval),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .m_o         (cur_m),
    .n_o         (cur_n)
  );

  rgs_serial_div #(
    .DIVIDEND_W(RATE_W),
    .DIVISOR_W (DSR_W)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (issue),
    .dividend_i (cand_dividend),
    .divisor_i  (cand_divisor),
    .busy_o     (div_busy),
    .valid_o    (div_valid),
    .quot_o     (div_quot)
  );

  rgs_best_track #(
    .RATE_W(RATE_W),
    .M_W   (M_W),
    .N_W   (N_W)
  ) u_best (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (accept),
    .eval_i      (eval),
    .target_i    (target_q),
    .cand_rate_i (div_quot),
    .cand_m_i    (cur_m),
    .cand_n_i    (cur_n),
    .best_rate_o (best_rate_o),
    .best_m_o    (best_m_o),
    .best_n_o    (best_n_o)
  );

  // R6: a new candidate is never launched over a running division.
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !div_busy);

  // R7: a start seen while busy leaves the latched rates untouched.
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(target_q) && $stable(base_q)));

  // R8: results hold while idle without a start.
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=>
      ($stable(best_rate_o) && $stable(best_m_o) && $stable(best_n_o)));

  // R5: a rate-0 candidate can never displace the initial choice.
  a_r5_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
    (best_rate_o == '0) |-> ((best_m_o == '0) && (best_n_o == '0)));

endmodule

// File: tb/rate_grid_search_tb_top.sv
module rate_grid_search_tb_top;

  localparam int RATE_W   = 32;
  localparam int M_COUNT  = 16;
  localparam int N_COUNT  = 8;
  localparam int PRE_DIV  = 2;
  localparam int M_OFFSET = 1;
  localparam int LATENCY  = M_COUNT * N_COUNT * (RATE_W + 2) + 1;

  typedef struct {
    int unsigned    m;
    int unsigned    n;
    longint unsigned rate;
    longint         t0;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [RATE_W-1:0] parent_rate_i = '0;
  logic [RATE_W-1:0] target_rate_i = '0;
  logic              busy_o;
  logic              done_o;
  logic [3:0]        best_m_o;
  logic [2:0]        best_n_o;
  logic [RATE_W-1:0] best_rate_o;

  int     n_checks = 0;
  int     n_fail   = 0;
  int     results_seen = 0;
  longint cyc = 0;
  exp_t   sb_q[$];
  exp_t   last_exp;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rate_grid_search #(
    .RATE_W(RATE_W), .M_COUNT(M_COUNT), .N_COUNT(N_COUNT),
    .PRE_DIV(PRE_DIV), .M_OFFSET(M_OFFSET)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .parent_rate_i(parent_rate_i), .target_rate_i(target_rate_i),
    .busy_o(busy_o), .done_o(done_o),
    .best_m_o(best_m_o), .best_n_o(best_n_o), .best_rate_o(best_rate_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Reference: walk the grid in the stated order, keep strictly closer fits.
  function automatic exp_t model(input longint unsigned p, input longint unsigned t);
    exp_t r;
    longint unsigned base, c, eb, ec;
    base = p / (PRE_DIV * 10);
    r.m = 0; r.n = 0; r.rate = 0; r.t0 = 0;
    for (int m = 0; m < M_COUNT; m++) begin
      for (int n = 0; n < N_COUNT; n++) begin
        c = (base / (longint'(1) << n)) / longint'(m + M_OFFSET);
        if (c <= t) begin
          ec = t - c;
          eb = t - r.rate;
          if (ec < eb) begin
            r.rate = c; r.m = m; r.n = n;
          end
        end
      end
    end
    return r;
  endfunction

  task automatic run_case(input longint unsigned p, input longint unsigned t, input bit poke_busy);
    exp_t e;
    int seen0;
    @(negedge clk);
    e = model(p, t);
    e.t0 = cyc;
    sb_q.push_back(e);
    last_exp = e;
    seen0 = results_seen;
    parent_rate_i = RATE_W'(p);
    target_rate_i = RATE_W'(t);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R6 busy after start", busy_o, 1);
    if (poke_busy) begin
      repeat (100) @(negedge clk);
      parent_rate_i = 32'hFFFF_FFFF;
      target_rate_i = 32'd7;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (results_seen == seen0) @(negedge clk);
    @(negedge clk);
    check(busy_o == 1'b0, "R6 busy low after done", busy_o, 0);
    check(done_o == 1'b0, "R6 done single cycle", done_o, 0);
  endtask

  // Monitor: pops the scoreboard on each done pulse.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check((cyc - e.t0) == LATENCY, "R6 done latency", cyc - e.t0, LATENCY);
        check(best_m_o == e.m, "R1 R2 R4 best M", best_m_o, e.m);
        check(best_n_o == e.n, "R1 R2 R4 best N", best_n_o, e.n);
        check(best_rate_o == e.rate, "R1 R3 best rate", best_rate_o, e.rate);
      end
      results_seen++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0, "R8 reset flags", {busy_o, done_o}, 0);
    check(best_rate_o == 0 && best_m_o == 0 && best_n_o == 0, "R8 reset outputs", best_rate_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(24_000_000, 100_000, 1'b0);
    run_case(2000, 50, 1'b0);
    check(best_m_o == 0 && best_n_o == 1 && best_rate_o == 50, "R4 tie keeps earlier",
          {best_m_o, best_n_o}, 1);
    run_case(1000, 1_000_000_000, 1'b0);
    check(best_m_o == 0 && best_n_o == 0 && best_rate_o == 50, "R1 target above base", best_rate_o, 50);
    run_case(2_000_000_000, 1000, 1'b0);
    check(best_rate_o == 0 && best_m_o == 0 && best_n_o == 0, "R5 all above target", best_rate_o, 0);
    run_case(123_456, 0, 1'b0);
    check(best_rate_o == 0, "R5 zero target", best_rate_o, 0);
    run_case(5, 3, 1'b0);
    check(best_rate_o == 0 && best_m_o == 0, "R5 zero base", best_rate_o, 0);
    run_case(32'hFFFF_FFFF, 32'h0012_3456, 1'b1);
    check(sb_q.size() == 0, "R7 no extra result queued", sb_q.size(), 0);
    repeat (20) @(negedge clk);
    check(best_rate_o == last_exp.rate && best_m_o == last_exp.m && best_n_o == last_exp.n,
          "R8 hold after done", best_rate_o, last_exp.rate);
    check(done_o == 1'b0 && busy_o == 1'b0, "R7 no late done", done_o, 0);
    run_case(100_000_000, 333_333, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 150_000);
    check(1'b0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule